// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns the 4-bit transmit nibbles that a MAC presents, together with their enable and error flags, into the three-level line symbol stream of 100BASE-TX. It emits one signed 2-bit level per 125 MHz bit time. A nibble strobe, high for one cycle in every five, marks when the nibble inputs are taken.

Inside, the stream passes through five fixed stages in order:

- a code-group mapper, which adds the frame delimiters, fills the idle gaps and maps each nibble to its 5-bit code;
- a serializer that sends the most significant bit first;
- an additive scrambler built on an 11-bit maximal-length LFSR;
- an NRZI stage;
- an MLT-3 level generator.

The analog driver, wave shaping and clock generation lie outside the block. They consume the registered level output.

Top module: `fe_tx_symbol_encoder`

## Requirements
- R1: While reset is high, and after it is released, the line level is 0 (code 2'b00). Reset also returns the framer to idle, the serializer to all ones, the level phase to 0 and the LFSR to its seed.
- R2: On a strobe with transmit enable low and no frame ending, the code group 11111 is sent, whatever the error flag and data are.
- R3: The first strobe with transmit enable high after idle sends 11000, and the next strobe sends 10001. The data nibbles and error flag on those two strobes are discarded.
- R4: During a frame, data nibbles map as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: During a frame, a nibble with the error flag high is sent as 00100 in place of its data code.
- R6: The first strobe in a frame with transmit enable low sends 01101, and the next strobe sends 00111 regardless of the inputs. Idle or a new frame follows.
- R7: Code groups are sent MSB first. Bit 4 is presented in the cycle after its strobe, and the line reflects a presented bit two clock edges later.
- R8: Each serial bit is XORed with key = s[10]^s[8] of the LFSR s. The LFSR shifts left every cycle, taking in the key (polynomial x^11+x^9+1), and never holds all zeros.
- R9: A scrambled 1 changes the line level in the next update, and a scrambled 0 keeps it.
- R10: Levels are coded 2'b00 = 0, 2'b01 = +1, 2'b11 = -1, and 2'b10 never appears. Transitions step through 0, +1, 0, -1 cyclically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_strobe | input | 1 | One-cycle pulse every fifth cycle; nibble inputs are taken on it |
| tx_en | input | 1 | Transmit enable from the MAC side |
| tx_er | input | 1 | Transmit error flag for the current nibble |
| txd | input | 4 | Transmit data nibble |
| line_lvl | output | 2 | Registered three-level line symbol |

## Verification
The bench builds the encoder with a non-default LFSR seed of 11'h5A3. This shows that the key stream depends on the seed parameter and not on a constant in the logic. The stimulus covers all sixteen data codes, both delimiter pairs, error substitution, errors that must be ignored, and a frame that restarts on the strobe right after an end delimiter. The bench runs the table twice with a reset in between. Several hundred consecutive bit times therefore pass through the scrambler, enough for the line comparison to expose a wrong tap, bit order or level sequence.

// File: rtl/fetx_pkg.sv
package fetx_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = 5;

  typedef enum logic [1:0] {FR_IDLE, FR_SEND_K, FR_DATA, FR_SEND_R} frame_st_t;

  localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
  localparam logic [GRP_W-1:0] CG_K    = 5'b10001;
  localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
  localparam logic [GRP_W-1:0] CG_R    = 5'b00111;
  localparam logic [GRP_W-1:0] CG_H    = 5'b00100;

  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;

  function automatic logic [GRP_W-1:0] data_group(input logic [NIB_W-1:0] n);
    logic [GRP_W-1:0] g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

  function automatic logic [1:0] phase_level(input logic [1:0] ph);
    logic [1:0] l;
    case (ph)
      2'd1: l = LVL_POS;
      2'd3: l = LVL_NEG;
      default: l = LVL_ZERO;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/fetx_group_map.sv
module fetx_group_map
  import fetx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [GRP_W-1:0] group
);
  frame_st_t state, state_nx;

  always_comb begin
    state_nx = state;
    group    = CG_IDLE;
    case (state)
      FR_IDLE: begin
        if (tx_en) begin
          group    = CG_J;
          state_nx = FR_SEND_K;
        end
      end
      FR_SEND_K: begin
        group    = CG_K;
        state_nx = FR_DATA;
      end
      FR_DATA: begin
        if (!tx_en) begin
          group    = CG_T;
          state_nx = FR_SEND_R;
        end else if (tx_er) begin
          group = CG_H;
        end else begin
          group = data_group(txd);
        end
      end
      default: begin
        group    = CG_R;
        state_nx = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= FR_IDLE;
    else if (strobe) state <= state_nx;
  end

  // R3
  start_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && state == FR_IDLE && tx_en) |=> (state == FR_SEND_K));

  // R6
  end_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && state == FR_DATA && !tx_en) |=> (state == FR_SEND_R));
endmodule

// File: rtl/fetx_serializer.sv
module fetx_serializer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         bit_o
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else if (load) sh <= din;
    else sh <= {sh[W-2:0], 1'b0};
  end

  assign bit_o = sh[W-1];

  // R7
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (bit_o == $past(din[W-1])));
endmodule

// File: rtl/fetx_scrambler.sv
module fetx_scrambler #(
  parameter int          LW   = 11,
  parameter int          TAP  = 9,
  parameter logic [LW-1:0] SEED = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic scr_o
);
  logic [LW-1:0] lfsr;
  logic          key;

  assign key = lfsr[LW-1] ^ lfsr[TAP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr  <= SEED;
      scr_o <= 1'b0;
    end else begin
      lfsr  <= {lfsr[LW-2:0], key};
      scr_o <= din ^ key;
    end
  end

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

// File: rtl/fetx_mlt3.sv
module fetx_mlt3
  import fetx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_i,
  output logic [1:0] line
);
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 2'd0;
      line  <= LVL_ZERO;
    end else if (bit_i) begin
      phase <= phase + 2'd1;
      line  <= phase_level(phase + 2'd1);
    end
  end

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_i) |-> $stable(line));

  // R9
  line_move_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bit_i) |-> !$stable(line));

  // R10
  line_code_chk: assert property (@(posedge clk) disable iff (rst)
    line != 2'b10);

  // R10
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(line) |-> (line == LVL_ZERO || $past(line) == LVL_ZERO));
endmodule

// File: rtl/fe_tx_symbol_encoder.sv
module fe_tx_symbol_encoder
  import fetx_pkg::*;
#(
  parameter int              LFSR_W    = 11,
  parameter int              LFSR_TAP  = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       nib_strobe,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [1:0] line_lvl
);
  logic [GRP_W-1:0] grp;
  logic             ser_bit;
  logic             scr_bit;

  fetx_group_map u_map (
    .clk(clk), .rst(rst), .strobe(nib_strobe),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .group(grp)
  );

  fetx_serializer #(.W(GRP_W)) u_ser (
    .clk(clk), .rst(rst), .load(nib_strobe), .din(grp), .bit_o(ser_bit)
  );

  fetx_scrambler #(.LW(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_SEED)) u_scr (
    .clk(clk), .rst(rst), .din(ser_bit), .scr_o(scr_bit)
  );

  fetx_mlt3 u_mlt (
    .clk(clk), .rst(rst), .bit_i(scr_bit), .line(line_lvl)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (line_lvl == LVL_ZERO));
endmodule

// File: tb/test_fe_tx_symbol_encoder.sv
module test_fe_tx_symbol_encoder;
  localparam logic [10:0] SEED = 11'h5A3;
  localparam int NV = 36;
  // {tx_en, tx_er, txd[3:0], expected code group[4:0]}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b0,4'h0,5'b11111}, {1'b0,1'b1,4'h3,5'b11111}, {1'b0,1'b0,4'hF,5'b11111},
    {1'b1,1'b0,4'h5,5'b11000}, {1'b1,1'b0,4'h5,5'b10001},
    {1'b1,1'b0,4'h0,5'b11110}, {1'b1,1'b0,4'h1,5'b01001}, {1'b1,1'b0,4'h2,5'b10100},
    {1'b1,1'b0,4'h3,5'b10101}, {1'b1,1'b0,4'h4,5'b01010}, {1'b1,1'b0,4'h5,5'b01011},
    {1'b1,1'b0,4'h6,5'b01110}, {1'b1,1'b0,4'h7,5'b01111}, {1'b1,1'b0,4'h8,5'b10010},
    {1'b1,1'b0,4'h9,5'b10011}, {1'b1,1'b0,4'hA,5'b10110}, {1'b1,1'b0,4'hB,5'b10111},
    {1'b1,1'b0,4'hC,5'b11010}, {1'b1,1'b0,4'hD,5'b11011}, {1'b1,1'b0,4'hE,5'b11100},
    {1'b1,1'b0,4'hF,5'b11101},
    {1'b1,1'b1,4'h7,5'b00100}, {1'b1,1'b0,4'hD,5'b11011},
    {1'b0,1'b0,4'h0,5'b01101}, {1'b0,1'b0,4'h0,5'b00111}, {1'b0,1'b0,4'h0,5'b11111},
    {1'b1,1'b0,4'h5,5'b11000}, {1'b1,1'b1,4'h5,5'b10001}, {1'b1,1'b0,4'hA,5'b10110},
    {1'b0,1'b1,4'h0,5'b01101}, {1'b1,1'b0,4'h5,5'b00111},
    {1'b1,1'b0,4'h5,5'b11000}, {1'b1,1'b0,4'h5,5'b10001},
    {1'b0,1'b0,4'h0,5'b01101}, {1'b0,1'b0,4'h0,5'b00111}, {1'b0,1'b0,4'h0,5'b11111}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nib_strobe = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [1:0] line_lvl;

  int n_chk = 0;
  int n_fail = 0;

  // bench reference state
  logic [4:0]  m_sh;
  logic        m_scr;
  logic [1:0]  m_ph;
  logic [1:0]  m_line;
  logic [10:0] m_lfsr;
  logic [4:0]  m_grp;
  string       t_sh, t_scr, t_line;

  always #4 clk = ~clk;

  fe_tx_symbol_encoder #(.LFSR_SEED(SEED)) i_fe_tx_symbol_encoder (
    .clk(clk), .rst(rst), .nib_strobe(nib_strobe),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .line_lvl(line_lvl)
  );

  function automatic string grp_tag(input logic [4:0] g);
    case (g)
      5'b11111: return "R2";
      5'b11000, 5'b10001: return "R3";
      5'b00100: return "R5";
      5'b01101, 5'b00111: return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [1:0] lvl_of(input logic [1:0] ph);
    case (ph)
      2'd1: return 2'b01;
      2'd3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic model_init();
    m_sh = 5'b11111; m_scr = 1'b0; m_ph = 2'd0; m_line = 2'b00;
    m_lfsr = SEED; m_grp = 5'b11111;
    t_sh = "R1"; t_scr = "R1"; t_line = "R1";
  endtask

  task automatic model_step();
    logic key;
    if (m_scr) m_ph = m_ph + 2'd1;
    m_line = lvl_of(m_ph);
    t_line = t_scr;
    key = m_lfsr[10] ^ m_lfsr[8];
    m_scr = m_sh[4] ^ key;
    m_lfsr = {m_lfsr[9:0], key};
    t_scr = t_sh;
    if (nib_strobe) begin
      m_sh = m_grp;
      t_sh = grp_tag(m_grp);
    end else begin
      m_sh = {m_sh[3:0], 1'b0};
    end
  endtask

  task automatic check_line(input string tag, input logic [1:0] exp);
    n_chk++;
    if (line_lvl !== exp) begin
      n_fail++;
      $display("FAIL %s (R7-path, R8, R9, R10): line_lvl actual %b expected %b at %0t",
               tag, line_lvl, exp, $time);
    end
  endtask

  task automatic run_vec(input int idx);
    for (int c = 0; c < 5; c++) begin
      nib_strobe = (c == 0);
      tx_en = VEC[idx][10];
      tx_er = VEC[idx][9];
      txd   = VEC[idx][8:5];
      m_grp = VEC[idx][4:0];
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_line(t_line, m_line);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; nib_strobe = 1'b0; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_line("R1", 2'b00);
    end
    rst = 1'b0;
    model_init();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    do_reset();
    // R2 R3 R4 R5 R6: table walk, every bit checked on the line (R7 R8 R9 R10)
    for (int v = 0; v < NV; v++) run_vec(v);
    // R1: reset in the middle of a frame, then the whole table again from a clean state
    for (int v = 0; v < 8; v++) run_vec(v);
    do_reset();
    @(negedge clk);
    check_line("R1", 2'b00);
    model_step();
    for (int v = 0; v < NV; v++) run_vec(v);
    // R2: long idle stretch exercises the scrambler free run
    for (int k = 0; k < 20; k++) run_vec(0);
    finish_run();
  end
endmodule